// File: doc/BRIEF.md
# Token-Passing FIFO Cascade Controller

This block is the expansion logic placed beside one FIFO so that several FIFOs can be chained into a deeper one. The FIFOs sit in a ring. Write ownership moves from each FIFO to the next as a one-clock low pulse on the write-expansion output, and that output drives the write-expansion input of the next FIFO. The last FIFO in the ring feeds the first one. Read ownership moves around the same ring on a second pair of pins, clocked by the read clock. A FIFO gives up its token when its last physical location is written (or read). The next FIFO in the ring takes the token on the clock edge that sees the low pulse.

The role of each FIFO is taken from its pins while reset is high. A low write-expansion pin with cascading selected makes the FIFO the master. The master starts out holding both tokens. In standalone and paralleled roles, no token is passed. The expansion outputs then carry the storage's half-full and empty flags, and the enables follow the local strobes. Storage and flag computation sit outside this block: the flags arrive as inputs and are registered out.

Top module: `token_ring_ctl`

## Requirements
- R1: While `rst` is high, the role is latched from the pins on each rising edge of its clock. `mode_sel`=0 gives standalone. With `mode_sel`=1: `wx_in`=0 gives master, `wx_in`=1 with `rx_in`=0 gives slave, and `wx_in`=1 with `rx_in`=1 gives paralleled. Master and slave are the cascaded roles.
- R2: On leaving reset, master, standalone and paralleled FIFOs have `wr_own`=1 and `rd_own`=1. A slave has both at 0.
- R3: `wr_en` equals `wr_req` AND `wr_own`, combinationally.
- R4: In a cascaded role, a write edge that sees `wr_en`=1 and `wr_last`=1 clears `wr_own` and drives `wx_out` low for exactly one `wclk` cycle.
- R5: In a cascaded role, a `wclk` edge that samples `wx_in`=0 (and does not emit) sets `wr_own` to 1.
- R6: In a cascaded role, `wx_out` is high at all times other than the R4 pulse, including during reset.
- R7: `rd_en` equals `rd_req` AND `rd_own`. In a cascaded role, a `rclk` edge that sees `rd_en`=1 and `rd_last`=1 clears `rd_own` and drives `rx_out` low for exactly one `rclk` cycle. Otherwise `rx_out` stays high.
- R8: In a cascaded role, a `rclk` edge that samples `rx_in`=0 (and does not emit) sets `rd_own` to 1.
- R9: In the standalone and paralleled roles, `wx_out` shows `hf_n` as sampled on the previous `wclk` edge, and `rx_out` shows `ef_n` as sampled on the previous `rclk` edge. Both read 1 during reset.
- R10: In the standalone and paralleled roles, `wx_in` and `rx_in` are ignored after reset. Ownership stays at 1, so `wr_en`=`wr_req` and `rd_en`=`rd_req`.
- R11: A `wr_last` pulse without `wr_req`, or without ownership, passes no token: `wx_out` stays high and `wr_own` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| mode_sel | input | 1 | Cascading select, sampled during reset |
| wr_req | input | 1 | Local write strobe |
| wr_last | input | 1 | This write targets the last physical location |
| wx_in | input | 1 | Write-expansion input / role pin during reset |
| hf_n | input | 1 | Active-low half-full flag from storage |
| rd_req | input | 1 | Local read strobe |
| rd_last | input | 1 | This read targets the last physical location |
| rx_in | input | 1 | Read-expansion input / role pin during reset |
| ef_n | input | 1 | Active-low empty flag from storage |
| wr_en | output | 1 | Write enable granted to storage |
| wr_own | output | 1 | Write token held |
| wx_out | output | 1 | Write-expansion output or half-full flag |
| rd_en | output | 1 | Read enable granted to storage |
| rd_own | output | 1 | Read token held |
| rx_out | output | 1 | Read-expansion output or empty flag |

## Verification
The bench builds the block with `FLAG_REG`=1, so the flag path is the registered one with its one-edge delay. Each role is entered in turn through reset. The two clocks are offset in phase, so both token sides run concurrently. The inputs include random token pulses and random last-location strobes, together with a scripted case where the last-location strobe arrives without a write strobe. These cover emission, receipt, the case where a token reaches a FIFO that already owns one, and the ignored-pin behaviour of the uncascaded roles.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    ROLE_STANDALONE = 2'd0,
    ROLE_PARALLEL   = 2'd1,
    ROLE_MASTER     = 2'd2,
    ROLE_SLAVE      = 2'd3
  } cas_role_t;

  // Role chosen from the pin levels present while reset is held.
  function automatic cas_role_t decode_role(input logic msel, input logic wx, input logic rx);
    if (!msel) return ROLE_STANDALONE;
    if (!wx)   return ROLE_MASTER;
    if (!rx)   return ROLE_SLAVE;
    return ROLE_PARALLEL;
  endfunction

  function automatic logic is_casc(input cas_role_t role);
    return (role == ROLE_MASTER) || (role == ROLE_SLAVE);
  endfunction

endpackage

// File: rtl/cas_role_latch.sv
module cas_role_latch
  import cas_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cas_role_t role_d,
  output cas_role_t role_q
);

  always_ff @(posedge clk) begin
    if (rst) role_q <= role_d;
  end

endmodule

// File: rtl/cas_token_side.sv
module cas_token_side
  import cas_pkg::*;
#(
  parameter int FLAG_REG = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  cas_role_t role_q,
  input  cas_role_t role_d,
  input  logic      pin_in,
  input  logic      req,
  input  logic      last,
  input  logic      flag_n,
  output logic      en,
  output logic      own,
  output logic      pin_out
);

  logic casc;
  logic emit;
  logic tok_n;
  logic flag_v;

  assign casc = is_casc(role_q);
  assign en   = req & own;
  assign emit = casc & en & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      own   <= (role_d != ROLE_SLAVE);
      tok_n <= 1'b1;
    end else if (casc) begin
      if (emit)         own <= 1'b0;
      else if (!pin_in) own <= 1'b1;
      tok_n <= ~emit;
    end else begin
      own   <= 1'b1;
      tok_n <= 1'b1;
    end
  end

  if (FLAG_REG != 0) begin : g_flag_reg
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b1;
      else     flag_q <= flag_n;
    end
    assign flag_v = flag_q;
  end else begin : g_flag_thru
    assign flag_v = flag_n;
  end

  assign pin_out = casc ? tok_n : flag_v;

endmodule

// File: rtl/token_ring_ctl.sv
module token_ring_ctl
  import cas_pkg::*;
#(
  parameter int FLAG_REG = 1
) (
  input  logic wclk,
  input  logic rclk,
  input  logic rst,
  input  logic mode_sel,
  input  logic wr_req,
  input  logic wr_last,
  input  logic wx_in,
  input  logic hf_n,
  input  logic rd_req,
  input  logic rd_last,
  input  logic rx_in,
  input  logic ef_n,
  output logic wr_en,
  output logic wr_own,
  output logic wx_out,
  output logic rd_en,
  output logic rd_own,
  output logic rx_out
);

  cas_role_t role_d;
  cas_role_t role_w;
  cas_role_t role_r;
  logic      casc_w;
  logic      casc_r;

  assign role_d = decode_role(mode_sel, wx_in, rx_in);
  assign casc_w = is_casc(role_w);
  assign casc_r = is_casc(role_r);

  cas_role_latch u_role_w (.clk(wclk), .rst(rst), .role_d(role_d), .role_q(role_w));
  cas_role_latch u_role_r (.clk(rclk), .rst(rst), .role_d(role_d), .role_q(role_r));

  cas_token_side #(.FLAG_REG(FLAG_REG)) u_wside (
    .clk(wclk), .rst(rst), .role_q(role_w), .role_d(role_d),
    .pin_in(wx_in), .req(wr_req), .last(wr_last), .flag_n(hf_n),
    .en(wr_en), .own(wr_own), .pin_out(wx_out)
  );

  cas_token_side #(.FLAG_REG(FLAG_REG)) u_rside (
    .clk(rclk), .rst(rst), .role_q(role_r), .role_d(role_d),
    .pin_in(rx_in), .req(rd_req), .last(rd_last), .flag_n(ef_n),
    .en(rd_en), .own(rd_own), .pin_out(rx_out)
  );

endmodule

// File: rtl/cas_checker.sv
module cas_checker
  import cas_pkg::*;
#(
  parameter int FLAG_REG = 1
) (
  input logic      wclk,
  input logic      rclk,
  input logic      rst,
  input cas_role_t role_w,
  input cas_role_t role_r,
  input logic      casc_w,
  input logic      casc_r,
  input logic      wr_req,
  input logic      wr_last,
  input logic      wx_in,
  input logic      hf_n,
  input logic      wr_en,
  input logic      wr_own,
  input logic      wx_out,
  input logic      rd_req,
  input logic      rd_last,
  input logic      rx_in,
  input logic      ef_n,
  input logic      rd_en,
  input logic      rd_own,
  input logic      rx_out
);

  AST_SLAVE_START_W: assert property (@(posedge wclk) disable iff (rst) $past(rst) && role_w == ROLE_SLAVE |-> !wr_own); // R2
  AST_SLAVE_START_R: assert property (@(posedge rclk) disable iff (rst) $past(rst) && role_r == ROLE_SLAVE |-> !rd_own); // R2
  AST_WR_EN_GATE: assert property (@(posedge wclk) disable iff (rst) wr_en |-> wr_own && wr_req); // R3
  AST_WR_EMIT: assert property (@(posedge wclk) disable iff (rst) casc_w && wr_req && wr_own && wr_last |=> !wx_out && !wr_own); // R4
  AST_WTOK_ONE_CYCLE: assert property (@(posedge wclk) disable iff (rst) casc_w && !wx_out |=> wx_out); // R4
  AST_WR_RECV: assert property (@(posedge wclk) disable iff (rst) casc_w && !wx_in && !(wr_req && wr_own && wr_last) |=> wr_own); // R5
  AST_WPIN_IDLE: assert property (@(posedge wclk) disable iff (rst) casc_w && !(wr_req && wr_own && wr_last) |=> wx_out); // R6
  AST_RD_EMIT: assert property (@(posedge rclk) disable iff (rst) casc_r && rd_req && rd_own && rd_last |=> !rx_out && !rd_own); // R7
  AST_RTOK_ONE_CYCLE: assert property (@(posedge rclk) disable iff (rst) casc_r && !rx_out |=> rx_out); // R7
  AST_RD_RECV: assert property (@(posedge rclk) disable iff (rst) casc_r && !rx_in && !(rd_req && rd_own && rd_last) |=> rd_own); // R8
  AST_SA_WOWN: assert property (@(posedge wclk) disable iff (rst) !casc_w |=> wr_own); // R10
  AST_SA_ROWN: assert property (@(posedge rclk) disable iff (rst) !casc_r |=> rd_own); // R10

  if (FLAG_REG != 0) begin : g_flag_chk
    AST_HF_PASS: assert property (@(posedge wclk) disable iff (rst) !casc_w |=> wx_out == $past(hf_n)); // R9
    AST_EF_PASS: assert property (@(posedge rclk) disable iff (rst) !casc_r |=> rx_out == $past(ef_n)); // R9
  end

endmodule

bind token_ring_ctl cas_checker #(.FLAG_REG(FLAG_REG)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .role_w(role_w), .role_r(role_r),
  .casc_w(casc_w), .casc_r(casc_r),
  .wr_req(wr_req), .wr_last(wr_last), .wx_in(wx_in), .hf_n(hf_n),
  .wr_en(wr_en), .wr_own(wr_own), .wx_out(wx_out),
  .rd_req(rd_req), .rd_last(rd_last), .rx_in(rx_in), .ef_n(ef_n),
  .rd_en(rd_en), .rd_own(rd_own), .rx_out(rx_out)
);

// File: tb/test_token_ring_ctl.sv
module test_token_ring_ctl;
  import cas_pkg::*;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1, mode_sel = 1'b0;
  logic wr_req = 1'b0, wr_last = 1'b0, wx_in = 1'b1, hf_n = 1'b1;
  logic rd_req = 1'b0, rd_last = 1'b0, rx_in = 1'b1, ef_n = 1'b1;
  logic wr_en, wr_own, wx_out, rd_en, rd_own, rx_out;

  int checks = 0;
  int fails  = 0;
  int wcyc   = 0;
  cas_role_t mrole = ROLE_STANDALONE;

  // reference state, updated from the requirements
  logic m_wown = 1'b1, m_wtok = 1'b1, m_wflag = 1'b1;
  logic m_rown = 1'b1, m_rtok = 1'b1, m_rflag = 1'b1;

  token_ring_ctl #(.FLAG_REG(1)) i_token_ring_ctl (
    .wclk(wclk), .rclk(rclk), .rst(rst), .mode_sel(mode_sel),
    .wr_req(wr_req), .wr_last(wr_last), .wx_in(wx_in), .hf_n(hf_n),
    .rd_req(rd_req), .rd_last(rd_last), .rx_in(rx_in), .ef_n(ef_n),
    .wr_en(wr_en), .wr_own(wr_own), .wx_out(wx_out),
    .rd_en(rd_en), .rd_own(rd_own), .rx_out(rx_out)
  );

  always #10 wclk = ~wclk;
  initial begin
    #7;
    forever #10 rclk = ~rclk;
  end

  function automatic logic casc_of(input cas_role_t r);
    return (r == ROLE_MASTER) || (r == ROLE_SLAVE);
  endfunction

  function automatic logic next_own(input logic c, input logic own, input logic req,
                                    input logic last, input logic pin);
    if (!c) return 1'b1;
    if (req && own && last) return 1'b0;
    if (!pin) return 1'b1;
    return own;
  endfunction

  function automatic logic next_tok(input logic c, input logic own, input logic req, input logic last);
    return !(c && req && own && last);
  endfunction

  always @(posedge wclk) begin
    wcyc++;
    if (rst) begin
      m_wown = (mrole != ROLE_SLAVE); m_wtok = 1'b1; m_wflag = 1'b1;
    end else begin
      m_wtok  = next_tok(casc_of(mrole), m_wown, wr_req, wr_last);
      m_wown  = next_own(casc_of(mrole), m_wown, wr_req, wr_last, wx_in);
      m_wflag = hf_n;
    end
  end

  always @(posedge rclk) begin
    if (rst) begin
      m_rown = (mrole != ROLE_SLAVE); m_rtok = 1'b1; m_rflag = 1'b1;
    end else begin
      m_rtok  = next_tok(casc_of(mrole), m_rown, rd_req, rd_last);
      m_rown  = next_own(casc_of(mrole), m_rown, rd_req, rd_last, rx_in);
      m_rflag = ef_n;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge wclk) begin
    if (wcyc > 150000) begin
      fails++;
      $display("FAIL watchdog all act=%0d exp<150000", wcyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wloop(input cas_role_t r, input int n);
    logic c;
    c = casc_of(r);
    for (int i = 0; i < n; i++) begin
      logic ep;
      @(negedge wclk);
      ep = c ? m_wtok : m_wflag;
      chk(c ? "R3" : "R10", "wr_en", wr_en, wr_req & m_wown);
      chk((i == 0) ? "R2" : (r == ROLE_MASTER && i == 1) ? "R11" : c ? "R5" : "R10",
          "wr_own", wr_own, m_wown);
      chk((i == 0) ? "R1" : (r == ROLE_MASTER && i == 1) ? "R11" : c ? (ep ? "R6" : "R4") : "R9",
          "wx_out", wx_out, ep);
      if (r == ROLE_MASTER && i == 0) begin
        wr_req = 1'b0; wr_last = 1'b1; wx_in = 1'b1; hf_n = 1'b1;
      end else if (r == ROLE_MASTER && i == 1) begin
        wr_req = 1'b1; wr_last = 1'b1; wx_in = 1'b1; hf_n = 1'b1;
      end else begin
        wr_req  = 1'($urandom % 2);
        wr_last = 1'(($urandom % 6) == 0);
        wx_in   = c ? 1'(($urandom % 10) != 0) : 1'($urandom % 2);
        hf_n    = 1'($urandom % 2);
      end
    end
  endtask

  task automatic rloop(input cas_role_t r, input int n);
    logic c;
    c = casc_of(r);
    for (int i = 0; i < n; i++) begin
      logic ep;
      @(negedge rclk);
      ep = c ? m_rtok : m_rflag;
      chk(c ? "R7" : "R10", "rd_en", rd_en, rd_req & m_rown);
      chk((i == 0) ? "R2" : c ? "R8" : "R10", "rd_own", rd_own, m_rown);
      chk((i == 0) ? "R1" : c ? "R7" : "R9", "rx_out", rx_out, ep);
      rd_req  = 1'($urandom % 2);
      rd_last = 1'(($urandom % 6) == 0);
      rx_in   = c ? 1'(($urandom % 10) != 0) : 1'($urandom % 2);
      ef_n    = 1'($urandom % 2);
    end
  endtask

  task automatic run_phase(input cas_role_t r, input int n);
    @(negedge wclk);
    rst = 1'b1;
    mrole = r;
    wr_req = 1'b0; wr_last = 1'b0; rd_req = 1'b0; rd_last = 1'b0;
    hf_n = 1'b1; ef_n = 1'b1;
    case (r)
      ROLE_STANDALONE: begin mode_sel = 1'b0; wx_in = 1'b1; rx_in = 1'b1; end
      ROLE_PARALLEL:   begin mode_sel = 1'b1; wx_in = 1'b1; rx_in = 1'b1; end
      ROLE_MASTER:     begin mode_sel = 1'b1; wx_in = 1'b0; rx_in = 1'b0; end
      default:         begin mode_sel = 1'b1; wx_in = 1'b1; rx_in = 1'b0; end
    endcase
    repeat (4) @(negedge wclk);
    chk(casc_of(r) ? "R6" : "R9", "wx_out in reset", wx_out, 1'b1);
    chk(casc_of(r) ? "R7" : "R9", "rx_out in reset", rx_out, 1'b1);
    chk("R2", "wr_own in reset", wr_own, r != ROLE_SLAVE);
    rst = 1'b0;
    wx_in = 1'b1; rx_in = 1'b1; mode_sel = 1'b0;
    fork
      wloop(r, n);
      rloop(r, n);
    join
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    run_phase(ROLE_STANDALONE, 2000);
    run_phase(ROLE_PARALLEL, 2000);
    run_phase(ROLE_MASTER, 3000);
    run_phase(ROLE_SLAVE, 3000);
    run_phase(ROLE_MASTER, 1000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule